// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block holds the stores that a processor core has dispatched but not yet retired, in program order. Each store is allocated with an age tag, and its address and data are written back later, each independently, by naming that tag. A store reaches memory only when it sits at the head of the buffer, has both its address and its data, and a retire request naming its tag arrives.

A load does not have to wait for the stores ahead of it to commit. It presents its age tag and word address, and in the same cycle the buffer searches every store that is older than the load. There are four possible answers:

- no older store gets in the way, so the load reads the cache;
- the youngest older store at the same address supplies the data;
- that store exists but its data has not arrived yet, so the load waits;
- an older store whose address is still unknown could be the true producer, so the result is an unresolved hazard.

A flush discards every store younger than a given age, for example after a mispredicted branch.

Top module: `store_fwd_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `mem_wr_valid` is 0, and any load gets result 00.
- R2: Allocation is accepted while fewer than DEPTH (default 8) stores are held. When the buffer is full, `alloc_ready` is 0 and an allocation request is ignored.
- R3: A load gets result 00 (read cache) when no store older than the load matches its address and no older store has an unknown address. Stores with the same age as the load, or younger, never take part in the search.
- R4: When one or more older stores match the load address on the full word address, the youngest of them is selected. If its data is present, the result is 01 and `ld_data` carries that data.
- R5: When the youngest older matching store has no data yet, the result is 10 (wait).
- R6: When an older store with an unknown address is younger than the youngest older match, or when there is no match at all, the result is 11 (unresolved). An unknown store that is older than the youngest match does not block forwarding.
- R7: Ages are compared modulo 2^TW. Tag a is older than tag b when the top bit of (a − b) is set, so ordering holds across the wrap from the largest tag to 0.
- R8: `mem_wr_valid` is 1 only in a cycle where `retire_valid` is 1, `retire_tag` equals the head store's tag, and the head store has both address and data. It then carries that store's address and data, and the head is removed at the clock edge. Any other retire request is ignored.
- R9: A flush removes every store younger than `flush_tag` and keeps the rest. In the flush cycle, allocation and retirement are ignored.
- R10: An address or data write naming a held store's tag updates that store, and the update is seen by loads from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a new youngest store |
| alloc_tag | input | TW | Age tag of the new store |
| alloc_ready | output | 1 | Buffer has a free slot |
| addr_wr_valid | input | 1 | Address writeback strobe |
| addr_wr_tag | input | TW | Tag of the store receiving the address |
| addr_wr_addr | input | AW | Word address |
| data_wr_valid | input | 1 | Data writeback strobe |
| data_wr_tag | input | TW | Tag of the store receiving the data |
| data_wr_data | input | DW | Store data |
| ld_valid | input | 1 | Load query present |
| ld_tag | input | TW | Age tag of the load |
| ld_addr | input | AW | Load word address |
| ld_result | output | 2 | 00 cache, 01 forward, 10 wait, 11 unresolved |
| ld_data | output | DW | Forwarded data, valid when result is 01 |
| retire_valid | input | 1 | Retire request |
| retire_tag | input | TW | Tag being retired |
| mem_wr_valid | output | 1 | Head store is written to memory this cycle |
| mem_wr_addr | output | AW | Address of the memory write |
| mem_wr_data | output | DW | Data of the memory write |
| flush_valid | input | 1 | Flush request |
| flush_tag | input | TW | Stores younger than this tag are removed |

## Verification
The load search is tried with several buffer contents:

- Two older stores at one address show that the youngest one wins, not the oldest.
- Moving the load tag between those two stores shows that younger stores are excluded.
- A matching store without data separates the wait result from forwarding.
- Placing an address-less store either younger or older than a match separates the unresolved result from a valid forward.
- A run of tags that wraps from 63 to 0 checks that the age ordering survives the wrap.

Retirement is tried with a tag that is not the head's and with a head that lacks data. A full buffer and a flush are each combined with a simultaneous allocation, and a later load shows whether the allocation was dropped.

// File: rtl/store_fwd_buf.sv
module store_fwd_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [TW-1:0] alloc_tag,
  output logic          alloc_ready,
  input  logic          addr_wr_valid,
  input  logic [TW-1:0] addr_wr_tag,
  input  logic [AW-1:0] addr_wr_addr,
  input  logic          data_wr_valid,
  input  logic [TW-1:0] data_wr_tag,
  input  logic [DW-1:0] data_wr_data,
  input  logic          ld_valid,
  input  logic [TW-1:0] ld_tag,
  input  logic [AW-1:0] ld_addr,
  output logic [1:0]    ld_result,
  output logic [DW-1:0] ld_data,
  input  logic          retire_valid,
  input  logic [TW-1:0] retire_tag,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          flush_valid,
  input  logic [TW-1:0] flush_tag
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [1:0] RES_CACHE = 2'b00;
  localparam logic [1:0] RES_FWD   = 2'b01;
  localparam logic [1:0] RES_WAIT  = 2'b10;
  localparam logic [1:0] RES_UNRES = 2'b11;

  logic [TW-1:0] tag_q  [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] aok_q, dok_q, live;
  logic [PW-1:0] head_q, tail;
  logic [CW-1:0] count_q, keep;
  logic push, pop;

  function automatic logic is_older(input logic [TW-1:0] a, input logic [TW-1:0] b);
    logic [TW-1:0] d;
    d = a - b;
    return d[TW-1];
  endfunction

  assign alloc_ready  = (count_q < CW'(DEPTH));
  assign tail         = head_q + count_q[PW-1:0];
  assign push         = alloc_valid && alloc_ready && !flush_valid;
  assign mem_wr_valid = retire_valid && !flush_valid && (count_q != '0) &&
                        (tag_q[head_q] == retire_tag) && aok_q[head_q] && dok_q[head_q];
  assign pop          = mem_wr_valid;
  assign mem_wr_addr  = addr_q[head_q];
  assign mem_wr_data  = data_q[head_q];

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      live[i] = ({1'b0, PW'(i) - head_q} < count_q);
  end

  // Scan from oldest to youngest so the last hit among older stores decides.
  always_comb begin
    logic [PW-1:0] s;
    ld_result = RES_CACHE;
    ld_data   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = head_q + PW'(k);
      if (ld_valid && (CW'(k) < count_q) && is_older(tag_q[s], ld_tag)) begin
        if (!aok_q[s]) begin
          ld_result = RES_UNRES;
        end else if (addr_q[s] == ld_addr) begin
          ld_result = dok_q[s] ? RES_FWD : RES_WAIT;
          ld_data   = data_q[s];
        end
      end
    end
  end

  // Program order means the removed stores form a suffix of the queue.
  always_comb begin
    logic [PW-1:0] s;
    keep = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = head_q + PW'(k);
      if ((CW'(k) < count_q) && !is_older(flush_tag, tag_q[s]))
        keep = keep + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (addr_wr_valid && live[i] && tag_q[i] == addr_wr_tag) addr_q[i] <= addr_wr_addr;
      if (data_wr_valid && live[i] && tag_q[i] == data_wr_tag) data_q[i] <= data_wr_data;
    end
    if (push) tag_q[tail] <= alloc_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
      aok_q   <= '0;
      dok_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (addr_wr_valid && live[i] && tag_q[i] == addr_wr_tag) aok_q[i] <= 1'b1;
        if (data_wr_valid && live[i] && tag_q[i] == data_wr_tag) dok_q[i] <= 1'b1;
      end
      if (flush_valid) begin
        count_q <= keep;
      end else begin
        if (push) begin
          aok_q[tail] <= 1'b0;
          dok_q[tail] <= 1'b0;
        end
        if (pop) head_q <= head_q + 1'b1;
        count_q <= count_q + CW'(push) - CW'(pop);
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH)); // R2
  AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && !mem_wr_valid && !flush_valid) |=> count_q == $past(count_q)); // R2
  AST_EMPTY_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && count_q == '0) |-> ld_result == RES_CACHE); // R3
  AST_DRAIN_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !alloc_valid) |=> count_q == $past(count_q) - 1'b1); // R8
  AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> count_q <= $past(count_q)); // R9
endmodule

// File: tb/store_fwd_buf_test.sv
module store_fwd_buf_test;
  logic clk = 0;
  logic rst_n = 0;
  logic alloc_valid = 0, addr_wr_valid = 0, data_wr_valid = 0, ld_valid = 0;
  logic retire_valid = 0, flush_valid = 0;
  logic [5:0] alloc_tag = 0, addr_wr_tag = 0, data_wr_tag = 0, ld_tag = 0, retire_tag = 0, flush_tag = 0;
  logic [31:0] addr_wr_addr = 0, data_wr_data = 0, ld_addr = 0;
  logic alloc_ready, mem_wr_valid;
  logic [1:0] ld_result;
  logic [31:0] ld_data, mem_wr_addr, mem_wr_data;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  store_fwd_buf uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic alloc(input logic [5:0] t);
    alloc_valid = 1; alloc_tag = t;
    @(negedge clk); alloc_valid = 0;
  endtask

  task automatic wr(input logic [5:0] t, input logic [31:0] a, input logic [31:0] d);
    addr_wr_valid = 1; addr_wr_tag = t; addr_wr_addr = a;
    data_wr_valid = 1; data_wr_tag = t; data_wr_data = d;
    @(negedge clk); addr_wr_valid = 0; data_wr_valid = 0;
  endtask

  task automatic wa(input logic [5:0] t, input logic [31:0] a);
    addr_wr_valid = 1; addr_wr_tag = t; addr_wr_addr = a;
    @(negedge clk); addr_wr_valid = 0;
  endtask

  task automatic wd(input logic [5:0] t, input logic [31:0] d);
    data_wr_valid = 1; data_wr_tag = t; data_wr_data = d;
    @(negedge clk); data_wr_valid = 0;
  endtask

  task automatic query(input logic [5:0] t, input logic [31:0] a, input logic [1:0] er,
                       input logic [31:0] ed, input string req);
    ld_valid = 1; ld_tag = t; ld_addr = a;
    #1;
    chk(ld_result == er, req, "load result", {30'b0, ld_result}, {30'b0, er});
    if (er == 2'b01) chk(ld_data == ed, req, "forwarded data", ld_data, ed);
    ld_valid = 0;
  endtask

  task automatic retire(input logic [5:0] t, input bit ew, input logic [31:0] ea,
                        input logic [31:0] ed, input string req);
    retire_valid = 1; retire_tag = t;
    #1;
    chk(mem_wr_valid == ew, req, "mem write strobe", {31'b0, mem_wr_valid}, {31'b0, ew});
    if (ew) begin
      chk(mem_wr_addr == ea, req, "mem write addr", mem_wr_addr, ea);
      chk(mem_wr_data == ed, req, "mem write data", mem_wr_data, ed);
    end
    @(negedge clk); retire_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(alloc_ready == 1, "R1", "ready after reset", {31'b0, alloc_ready}, 1);
    chk(mem_wr_valid == 0, "R1", "no write after reset", {31'b0, mem_wr_valid}, 0);
    query(6'd5, 32'h100, 2'b00, 0, "R1");
  endtask

  task automatic t_forward;
    alloc(1); alloc(2); alloc(3);
    wr(1, 32'h100, 32'hA1); wr(2, 32'h200, 32'hB2); wr(3, 32'h100, 32'hC3);
    query(6'd4, 32'h100, 2'b01, 32'hC3, "R4 youngest match");
    query(6'd3, 32'h100, 2'b01, 32'hA1, "R4 only older stores");
    query(6'd4, 32'h300, 2'b00, 0, "R3 no match");
    query(6'd1, 32'h100, 2'b00, 0, "R3 nothing older");
  endtask

  task automatic t_wait_unres;
    alloc(4); wa(4, 32'h200);
    query(6'd5, 32'h200, 2'b10, 0, "R5 wait for data");
    query(6'd5, 32'h100, 2'b01, 32'hC3, "R4 other address");
    alloc(5);
    query(6'd6, 32'h100, 2'b11, 0, "R6 unknown address");
    query(6'd5, 32'h100, 2'b01, 32'hC3, "R3 same-age store excluded");
    wr(5, 32'h300, 32'hE5);
    query(6'd6, 32'h100, 2'b01, 32'hC3, "R10 address written back");
  endtask

  task automatic t_retire;
    retire(2, 0, 0, 0, "R8 not head");
    retire(1, 1, 32'h100, 32'hA1, "R8 head");
    query(6'd6, 32'h200, 2'b10, 0, "R8 remaining store");
    retire(2, 1, 32'h200, 32'hB2, "R8");
    retire(3, 1, 32'h100, 32'hC3, "R8");
    retire(4, 0, 0, 0, "R8 head lacks data");
    wd(4, 32'hD4);
    query(6'd6, 32'h200, 2'b01, 32'hD4, "R10 data written back");
    retire(4, 1, 32'h200, 32'hD4, "R8");
    retire(5, 1, 32'h300, 32'hE5, "R8");
    query(6'd6, 32'h300, 2'b00, 0, "R8 drained");
  endtask

  task automatic t_full_flush;
    for (int i = 10; i < 18; i++) begin
      alloc(6'(i));
      wr(6'(i), 32'h400 + 32'(4 * (i - 10)), 32'h1000 + 32'(i));
    end
    #1 chk(alloc_ready == 0, "R2", "ready when full", {31'b0, alloc_ready}, 0);
    alloc(18);
    query(6'd19, 32'h500, 2'b00, 0, "R2 alloc when full ignored");
    flush_valid = 1; flush_tag = 13; alloc_valid = 1; alloc_tag = 20;
    @(negedge clk); flush_valid = 0; alloc_valid = 0;
    query(6'd19, 32'h414, 2'b00, 0, "R9 younger store removed");
    query(6'd19, 32'h40C, 2'b01, 32'h100D, "R9 flush tag kept");
    query(6'd21, 32'h900, 2'b00, 0, "R9 alloc in flush ignored");
    #1 chk(alloc_ready == 1, "R9", "ready after flush", {31'b0, alloc_ready}, 1);
    alloc(14); alloc(15); wr(15, 32'h400, 32'hF5);
    query(6'd16, 32'h400, 2'b01, 32'hF5, "R6 older unknown does not block");
    query(6'd16, 32'h404, 2'b11, 0, "R6 unknown younger than match");
    for (int i = 10; i < 14; i++)
      retire(6'(i), 1, 32'h400 + 32'(4 * (i - 10)), 32'h1000 + 32'(i), "R8 drain");
    retire(14, 0, 0, 0, "R8 head lacks address");
    flush_valid = 1; flush_tag = 13;
    @(negedge clk); flush_valid = 0;
    query(6'd16, 32'h400, 2'b00, 0, "R9 flush empties");
  endtask

  task automatic t_wrap;
    alloc(62); alloc(63); alloc(0);
    wr(62, 32'h700, 32'h62); wr(63, 32'h700, 32'h63); wr(0, 32'h700, 32'hAA);
    query(6'd1, 32'h700, 2'b01, 32'hAA, "R7 tag 0 older than 1");
    query(6'd0, 32'h700, 2'b01, 32'h63, "R7 tag 63 older than 0");
    query(6'd63, 32'h700, 2'b01, 32'h62, "R7");
  endtask

  initial begin
    #4_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_forward();
    t_wait_unres();
    t_retire();
    t_full_flush();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule